// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller brings one cache line in from a pipelined Wishbone slave after a load miss. It fetches the word that missed first and then walks the remaining rows of the line in ascending order, wrapping past the end. Every returning word goes straight into the data array of the chosen way. A valid bit per row records that the word has landed. The missed load is answered from a forwarding register one cycle after its word arrives, so it does not wait for the rest of the line. A probe port lets the surrounding pipeline ask whether a newer load to the same line can already be treated as a hit.

The same machinery also zeroes a line. For this operation the controller issues eight bus writes of zero with every byte lane enabled, writes zeros into the array, and allocates the line. The tag is written only when the line was not already present. Victim selection is done outside the block: the chosen way arrives with the request.

Top module: `line_refill_ctrl`

## Requirements
- R1: After reset, `idle_o` is 1 and `wb_cyc_o`, `wb_stb_o`, `arr_we_o`, `tag_we_o`, `done_o` and `probe_hit_o` are all 0.
- R2: A request is taken only in a cycle where `idle_o` is 1 and `req_valid_i` is 1. `idle_o` stays 0 until the refill ends, and a request presented while busy has no effect.
- R3: The bus issues exactly 8 addresses. The byte address is {line, row, 3'b000}, where the line is `req_wadr_i[28:3]` and the row is 3 bits. The first row is `req_wadr_i[2:0]` and each later row is the previous one plus 1 modulo 8. While `wb_stall_i` is 1, the strobe and address are held.
- R4: `wb_stb_o` falls once the eighth address has been accepted. `wb_cyc_o` falls, and `idle_o` rises, in the cycle after the acknowledge for the last row (start row minus 1, modulo 8).
- R5: Each acknowledge writes one array entry in the same cycle. It uses the request's way, index `req_wadr_i[8:3]` and the rows in issue order. For a load refill the written data is `wb_dat_i`.
- R6: `probe_hit_o` is 1 only while busy, for a probe word address in the line being refilled whose row has already been acknowledged. All row valid bits clear when a refill is accepted.
- R7: `done_o` is a one-cycle pulse in the cycle after the acknowledge of the start row. `done_dat_o` then holds that row's data.
- R8: `tag_we_o` is a one-cycle pulse in the cycle after acceptance. It carries the request's way, index and tag `req_wadr_i[28:9]`.
- R9: When `req_zero_i` is 1, every bus access has `wb_we_o`=1, `wb_dat_o`=0 and `wb_sel_o`=8'hFF, every array write carries zero, and `done_dat_o` is 0. The row order is the same as for a load refill.
- R10: A zeroing request with `req_hit_i`=1 produces no tag write. With `req_hit_i`=0 it writes the tag. For a load refill `req_hit_i` is ignored and the tag is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request strobe |
| req_wadr_i | input | 29 | Word address of the missed load |
| req_way_i | input | 2 | Way to fill |
| req_zero_i | input | 1 | Request is a line zero instead of a refill |
| req_hit_i | input | 1 | Zeroed line is already present (skip tag write) |
| idle_o | output | 1 | Ready to accept a request |
| probe_wadr_i | input | 29 | Word address of a newer load |
| probe_hit_o | output | 1 | Probe row already filled |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 32 | Bus byte address |
| wb_sel_o | output | 8 | Bus byte selects |
| wb_dat_o | output | 64 | Bus write data |
| wb_dat_i | input | 64 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |
| wb_stall_i | input | 1 | Bus stall |
| arr_we_o | output | 1 | Data array write enable |
| arr_way_o | output | 2 | Data array way |
| arr_idx_o | output | 6 | Data array set index |
| arr_row_o | output | 3 | Data array row in line |
| arr_dat_o | output | 64 | Data array write data |
| tag_we_o | output | 1 | Tag write enable |
| tag_way_o | output | 2 | Tag way |
| tag_idx_o | output | 6 | Tag set index |
| tag_val_o | output | 20 | Tag value |
| done_o | output | 1 | Missed load completes |
| done_dat_o | output | 64 | Forwarded word |

## Verification
Several rules are checked by assertions on every cycle:
- the strobe stays inside the bus cycle;
- the address is frozen under stall;
- each accepted address advances the row by one, modulo 8;
- array writes occur only within the cycle, and are zero when the cycle is a write;
- the tag write and the completion are single-cycle pulses.

Other behaviour depends on values the assertions cannot know, so only the bench scenarios can show it:
- that the first row is the missed one and the count of addresses is eight;
- that the array writes carry the right data, way and index;
- that completion lands exactly one cycle after the start row's acknowledge;
- that valid bits clear between refills;
- that a zeroing hit skips the tag.

// File: rtl/line_refill_pkg.sv
package line_refill_pkg;
  localparam int RF_DATA_W = 64;
  localparam int RF_BYTES  = RF_DATA_W / 8;

  typedef enum logic {
    RF_IDLE = 1'b0,
    RF_BUSY = 1'b1
  } rf_state_e;
endpackage

// File: rtl/lr_issue.sv
// Bus address sequencer: wraps rows from the start row, drops strobe after ROWS accepts.
module lr_issue #(
  parameter int ROWS = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int CNT_W = ROW_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] start_row_i,
  input  logic             stall_i,
  output logic             stb_o,
  output logic [ROW_W-1:0] row_o
);
  logic             stb_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      row_q  <= '0;
      sent_q <= '0;
    end else if (start_i) begin
      stb_q  <= 1'b1;
      row_q  <= start_row_i;
      sent_q <= '0;
    end else if (stb_q && !stall_i) begin
      row_q  <= row_q + 1'b1;
      sent_q <= sent_q + 1'b1;
      if (sent_q == CNT_W'(ROWS - 1)) stb_q <= 1'b0;
    end
  end

  assign stb_o = stb_q;
  assign row_o = row_q;
endmodule

// File: rtl/lr_track.sv
// Acknowledge tracker: row of each returning word, per-row valid map, first/last detect.
module lr_track #(
  parameter int ROWS = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] start_row_i,
  input  logic             ack_i,
  output logic [ROW_W-1:0] ack_row_o,
  output logic             first_o,
  output logic             last_o,
  output logic [ROWS-1:0]  vld_o
);
  logic [ROW_W-1:0] start_q;
  logic [ROW_W-1:0] ack_row_q;
  logic [ROWS-1:0]  vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= '0;
      ack_row_q <= '0;
    end else if (start_i) begin
      start_q   <= start_row_i;
      ack_row_q <= start_row_i;
    end else if (ack_i) begin
      ack_row_q <= ack_row_q + 1'b1;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_vld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  vld_q[r] <= 1'b0;
      else if (start_i)                             vld_q[r] <= 1'b0;
      else if (ack_i && ack_row_q == ROW_W'(r))     vld_q[r] <= 1'b1;
    end
  end

  assign ack_row_o = ack_row_q;
  assign first_o   = ack_i && (ack_row_q == start_q);
  assign last_o    = ack_i && (ack_row_q == ROW_W'(start_q - 1'b1));
  assign vld_o     = vld_q;
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
  import line_refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 8,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  localparam int OFF_W  = $clog2(RF_BYTES),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WADR_W = ADDR_W - OFF_W,
  localparam int LINE_W = WADR_W - ROW_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [WADR_W-1:0]    req_wadr_i,
  input  logic [WAY_W-1:0]     req_way_i,
  input  logic                 req_zero_i,
  input  logic                 req_hit_i,
  output logic                 idle_o,
  input  logic [WADR_W-1:0]    probe_wadr_i,
  output logic                 probe_hit_o,
  output logic                 wb_cyc_o,
  output logic                 wb_stb_o,
  output logic                 wb_we_o,
  output logic [ADDR_W-1:0]    wb_adr_o,
  output logic [RF_BYTES-1:0]  wb_sel_o,
  output logic [RF_DATA_W-1:0] wb_dat_o,
  input  logic [RF_DATA_W-1:0] wb_dat_i,
  input  logic                 wb_ack_i,
  input  logic                 wb_stall_i,
  output logic                 arr_we_o,
  output logic [WAY_W-1:0]     arr_way_o,
  output logic [IDX_W-1:0]     arr_idx_o,
  output logic [ROW_W-1:0]     arr_row_o,
  output logic [RF_DATA_W-1:0] arr_dat_o,
  output logic                 tag_we_o,
  output logic [WAY_W-1:0]     tag_way_o,
  output logic [IDX_W-1:0]     tag_idx_o,
  output logic [TAG_W-1:0]     tag_val_o,
  output logic                 done_o,
  output logic [RF_DATA_W-1:0] done_dat_o
);
  rf_state_e              state_q;
  logic                   zero_q;
  logic [WAY_W-1:0]       way_q;
  logic [LINE_W-1:0]      line_q;
  logic                   tag_we_q;
  logic                   done_q;
  logic [RF_DATA_W-1:0]   done_dat_q;

  logic                   busy;
  logic                   accept;
  logic                   ack;
  logic                   stb;
  logic [ROW_W-1:0]       iss_row;
  logic [ROW_W-1:0]       ack_row;
  logic                   first_ack;
  logic                   last_ack;
  logic [ROWS-1:0]        row_vld;
  logic [RF_DATA_W-1:0]   fill_dat;

  assign busy     = (state_q == RF_BUSY);
  assign accept   = req_valid_i && !busy;
  assign ack      = busy && wb_ack_i;
  assign fill_dat = zero_q ? '0 : wb_dat_i;

  lr_issue #(.ROWS(ROWS)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .start_row_i (req_wadr_i[ROW_W-1:0]),
    .stall_i     (wb_stall_i),
    .stb_o       (stb),
    .row_o       (iss_row)
  );

  lr_track #(.ROWS(ROWS)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .start_row_i (req_wadr_i[ROW_W-1:0]),
    .ack_i       (ack),
    .ack_row_o   (ack_row),
    .first_o     (first_ack),
    .last_o      (last_ack),
    .vld_o       (row_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RF_IDLE;
      zero_q     <= 1'b0;
      way_q      <= '0;
      line_q     <= '0;
      tag_we_q   <= 1'b0;
      done_q     <= 1'b0;
      done_dat_q <= '0;
    end else begin
      tag_we_q <= accept && !(req_zero_i && req_hit_i);
      done_q   <= first_ack;
      if (first_ack) done_dat_q <= fill_dat;
      if (accept) begin
        state_q <= RF_BUSY;
        zero_q  <= req_zero_i;
        way_q   <= req_way_i;
        line_q  <= req_wadr_i[WADR_W-1:ROW_W];
      end else if (last_ack) begin
        state_q <= RF_IDLE;
      end
    end
  end

  // probe: newer load to the refilling line hits once its row has landed
  assign probe_hit_o = busy && (probe_wadr_i[WADR_W-1:ROW_W] == line_q)
                       && row_vld[probe_wadr_i[ROW_W-1:0]];

  assign idle_o   = !busy;
  assign wb_cyc_o = busy;
  assign wb_stb_o = stb;
  assign wb_we_o  = busy && zero_q;
  assign wb_adr_o = {line_q, iss_row, {OFF_W{1'b0}}};
  assign wb_sel_o = '1;
  assign wb_dat_o = '0;

  assign arr_we_o  = ack;
  assign arr_way_o = way_q;
  assign arr_idx_o = line_q[IDX_W-1:0];
  assign arr_row_o = ack_row;
  assign arr_dat_o = fill_dat;

  assign tag_we_o  = tag_we_q;
  assign tag_way_o = way_q;
  assign tag_idx_o = line_q[IDX_W-1:0];
  assign tag_val_o = line_q[LINE_W-1:IDX_W];

  assign done_o     = done_q;
  assign done_dat_o = done_dat_q;
endmodule

// File: rtl/line_refill_ctrl_chk.sv
module line_refill_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 8,
  localparam int OFF_W = 3,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic              wb_we_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic              wb_stall_i,
  input logic              arr_we_o,
  input logic [63:0]       arr_dat_o,
  input logic              tag_we_o,
  input logic              done_o
);
  assert_stb_in_cyc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o);

  assert_hold_on_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o && wb_stall_i |=> wb_stb_o && $stable(wb_adr_o));

  assert_row_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o && !wb_stall_i |=> !wb_stb_o ||
      wb_adr_o[OFF_W+ROW_W-1:OFF_W] == ROW_W'($past(wb_adr_o[OFF_W+ROW_W-1:OFF_W]) + 1'b1));

  assert_write_in_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> wb_cyc_o);

  assert_zero_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o && wb_we_o |-> arr_dat_o == '0);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_tag_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |=> !tag_we_o);
endmodule

bind line_refill_ctrl line_refill_ctrl_chk #(.ADDR_W(ADDR_W), .ROWS(ROWS)) u_chk (.*);

// File: tb/line_refill_ctrl_test.sv
module line_refill_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [28:0] req_wadr_i = '0;
  logic [1:0]  req_way_i = '0;
  logic        req_zero_i = 1'b0;
  logic        req_hit_i = 1'b0;
  logic        idle_o;
  logic [28:0] probe_wadr_i = '0;
  logic        probe_hit_o;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [31:0] wb_adr_o;
  logic [7:0]  wb_sel_o;
  logic [63:0] wb_dat_o;
  logic [63:0] wb_dat_i;
  logic        wb_ack_i;
  logic        wb_stall_i;
  logic        arr_we_o;
  logic [1:0]  arr_way_o;
  logic [5:0]  arr_idx_o;
  logic [2:0]  arr_row_o;
  logic [63:0] arr_dat_o;
  logic        tag_we_o;
  logic [1:0]  tag_way_o;
  logic [5:0]  tag_idx_o;
  logic [19:0] tag_val_o;
  logic        done_o;
  logic [63:0] done_dat_o;

  always #5 clk = ~clk;

  line_refill_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_wadr_i(req_wadr_i),
    .req_way_i(req_way_i), .req_zero_i(req_zero_i), .req_hit_i(req_hit_i), .idle_o(idle_o),
    .probe_wadr_i(probe_wadr_i), .probe_hit_o(probe_hit_o),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o),
    .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i),
    .wb_stall_i(wb_stall_i), .arr_we_o(arr_we_o), .arr_way_o(arr_way_o), .arr_idx_o(arr_idx_o),
    .arr_row_o(arr_row_o), .arr_dat_o(arr_dat_o), .tag_we_o(tag_we_o), .tag_way_o(tag_way_o),
    .tag_idx_o(tag_idx_o), .tag_val_o(tag_val_o), .done_o(done_o), .done_dat_o(done_dat_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc_n  = 0;
  logic stall_all = 1'b0;
  logic rand_en = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  int acc_n, wr_n, tag_n, done_n, done_cyc;
  logic [31:0] acc_adr [16];
  logic        acc_we  [16];
  logic [63:0] acc_dat [16];
  logic [7:0]  acc_sel [16];
  logic [2:0]  wr_row  [16];
  logic [63:0] wr_dat  [16];
  logic [1:0]  wr_way  [16];
  logic [5:0]  wr_idx  [16];
  int          wr_cyc  [16];
  logic [1:0]  tag_way_s;
  logic [5:0]  tag_idx_s;
  logic [19:0] tag_val_s;
  logic [63:0] done_dat_s;

  function automatic logic [63:0] mem_word(logic [31:0] a);
    return {a, ~a};
  endfunction

  assign wb_stall_i = stall_all | (rand_en & lfsr[0]);

  // slave: one-cycle acknowledge latency, fully pipelined; plus output monitor
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_ack_i <= 1'b0;
      wb_dat_i <= '0;
    end else begin
      cyc_n++;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (wb_cyc_o && wb_stb_o && !wb_stall_i) begin
        if (acc_n < 16) begin
          acc_adr[acc_n] = wb_adr_o; acc_we[acc_n] = wb_we_o;
          acc_dat[acc_n] = wb_dat_o; acc_sel[acc_n] = wb_sel_o;
        end
        acc_n++;
        wb_ack_i <= 1'b1;
        wb_dat_i <= mem_word(wb_adr_o);
      end else begin
        wb_ack_i <= 1'b0;
      end
      if (arr_we_o) begin
        if (wr_n < 16) begin
          wr_row[wr_n] = arr_row_o; wr_dat[wr_n] = arr_dat_o;
          wr_way[wr_n] = arr_way_o; wr_idx[wr_n] = arr_idx_o; wr_cyc[wr_n] = cyc_n;
        end
        wr_n++;
      end
      if (tag_we_o) begin
        tag_n++; tag_way_s = tag_way_o; tag_idx_s = tag_idx_o; tag_val_s = tag_val_o;
      end
      if (done_o) begin
        done_n++; done_dat_s = done_dat_o; done_cyc = cyc_n;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc_n > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_n);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic clear_logs();
    acc_n = 0; wr_n = 0; tag_n = 0; done_n = 0; done_cyc = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && !idle_o; i++) @(negedge clk);
  endtask

  task automatic issue(input logic [28:0] wadr, input logic [1:0] way, input bit zero, input bit hit);
    req_wadr_i = wadr; req_way_i = way; req_zero_i = zero; req_hit_i = hit;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic verify(input logic [28:0] wadr, input logic [1:0] way, input bit zero, input bit hit);
    logic [2:0]  st;
    logic [31:0] ea;
    bit          exp_tag;
    st = wadr[2:0];
    exp_tag = !(zero && hit);
    check(acc_n == 8, "R3 address count", 64'(acc_n), 64'd8);
    for (int k = 0; k < 8; k++) begin
      ea = {wadr[28:3], 3'(st + 3'(k)), 3'b000};
      check(acc_adr[k] == ea, "R3 address order", 64'(acc_adr[k]), 64'(ea));
      if (zero) begin
        check(acc_we[k] && acc_dat[k] == 0 && acc_sel[k] == 8'hff, "R9 zero write",
              {acc_sel[k], 55'd0, acc_we[k]}, {8'hff, 55'd0, 1'b1});
      end else begin
        check(!acc_we[k], "R5 read access", 64'(acc_we[k]), 64'd0);
      end
    end
    check(wr_n == 8, "R5 array write count", 64'(wr_n), 64'd8);
    for (int k = 0; k < 8; k++) begin
      ea = {wadr[28:3], 3'(st + 3'(k)), 3'b000};
      check(wr_row[k] == 3'(st + 3'(k)), "R5 array row", 64'(wr_row[k]), 64'(3'(st + 3'(k))));
      check(wr_dat[k] == (zero ? 64'd0 : mem_word(ea)), zero ? "R9 array zero" : "R5 array data",
            wr_dat[k], zero ? 64'd0 : mem_word(ea));
      check(wr_way[k] == way && wr_idx[k] == wadr[8:3], "R5 array way/index",
            {wr_way[k], wr_idx[k]}, {way, wadr[8:3]});
    end
    check(tag_n == int'(exp_tag), "R10 tag write count", 64'(tag_n), 64'(exp_tag));
    if (exp_tag && tag_n == 1)
      check(tag_way_s == way && tag_idx_s == wadr[8:3] && tag_val_s == wadr[28:9], "R8 tag fields",
            {tag_way_s, tag_idx_s, tag_val_s}, {way, wadr[8:3], wadr[28:9]});
    check(done_n == 1, "R7 completion count", 64'(done_n), 64'd1);
    check(done_dat_s == (zero ? 64'd0 : mem_word({wadr, 3'b000})), "R7 forwarded data",
          done_dat_s, zero ? 64'd0 : mem_word({wadr, 3'b000}));
    check(done_cyc == wr_cyc[0] + 1, "R7 completion timing", 64'(done_cyc), 64'(wr_cyc[0] + 1));
    check(!wb_cyc_o && !wb_stb_o && idle_o, "R4 bus released", {wb_cyc_o, wb_stb_o, idle_o}, 3'b001);
  endtask

  task automatic t_reset();
    check(idle_o && !wb_cyc_o && !wb_stb_o && !arr_we_o && !tag_we_o && !done_o && !probe_hit_o,
          "R1 reset state",
          {idle_o, wb_cyc_o, wb_stb_o, arr_we_o, tag_we_o, done_o, probe_hit_o}, 7'b1000000);
  endtask

  task automatic t_refill(input logic [28:0] wadr, input logic [1:0] way, input bit zero,
                          input bit hit, input bit rnd);
    clear_logs();
    rand_en = rnd;
    check(idle_o, "R2 idle before request", 64'(idle_o), 64'd1);
    issue(wadr, way, zero, hit);
    check(!idle_o, "R2 busy after accept", 64'(idle_o), 64'd0);
    wait_idle();
    rand_en = 1'b0;
    verify(wadr, way, zero, hit);
  endtask

  task automatic t_probe(input logic [28:0] wadr);
    clear_logs();
    stall_all = 1'b1;
    issue(wadr, 2'd1, 1'b0, 1'b0);
    // request while busy must be ignored
    issue({wadr[28:3] + 26'd5, 3'd0}, 2'd3, 1'b1, 1'b1);
    @(negedge clk);
    probe_wadr_i = wadr;
    #1 check(!probe_hit_o, "R6 valid bits cleared at start", 64'(probe_hit_o), 64'd0);
    stall_all = 1'b0;
    @(negedge clk);
    stall_all = 1'b1;
    @(negedge clk);
    @(negedge clk);
    probe_wadr_i = wadr;
    #1 check(probe_hit_o, "R6 filled row hits", 64'(probe_hit_o), 64'd1);
    probe_wadr_i = {wadr[28:3], 3'(wadr[2:0] + 3'd1)};
    #1 check(!probe_hit_o, "R6 unfilled row misses", 64'(probe_hit_o), 64'd0);
    probe_wadr_i = {wadr[28:3] + 26'd1, wadr[2:0]};
    #1 check(!probe_hit_o, "R6 other line misses", 64'(probe_hit_o), 64'd0);
    stall_all = 1'b0;
    wait_idle();
    probe_wadr_i = wadr;
    #1 check(!probe_hit_o, "R6 no hit when idle", 64'(probe_hit_o), 64'd0);
    verify(wadr, 2'd1, 1'b0, 1'b0);
    check(tag_n == 1, "R2 busy request ignored", 64'(tag_n), 64'd1);
  endtask

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_refill(29'h0123_4560, 2'd0, 1'b0, 1'b0, 1'b0);
    t_refill(29'h0abc_def5, 2'd2, 1'b0, 1'b0, 1'b1);
    t_refill(29'h1fff_ffff, 2'd3, 1'b0, 1'b1, 1'b1);
    t_refill(29'h0055_5553, 2'd1, 1'b1, 1'b0, 1'b0);
    t_refill(29'h0066_6667, 2'd2, 1'b1, 1'b1, 1'b1);
    t_refill(29'h0123_4562, 2'd0, 1'b0, 1'b0, 1'b0);
    t_probe(29'h0123_4562);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule